// File: doc/BRIEF.md
# Frame-Rate-Control Grayscale and Colour Dither

This block turns 3-bit intensity values into 1-bit-per-channel drive for a panel that can only switch each subpixel fully on or fully off. It creates intermediate shades by lighting a pixel in some frames and not in others. A level of n lights the pixel in n frames out of every 7. Each screen position gets a different phase within the 7-frame cycle, so neighbouring pixels at the same level do not all flash together, and the flicker is spread across the screen.

There are two modes. In monochrome mode the block reads one 3-bit gray value and drives one output bit, which gives eight shades from fully dark to fully lit. In colour mode it reads three 3-bit fields (red, green and blue) and drives three output bits, which gives 512 apparent colours. The colour channels share the same pattern, but each has its own fixed phase offset. The pixel stream supplies the coordinates and a valid flag. A frame-start strobe advances an internal frame index. The result appears one clock later, registered, together with its valid flag.

Top module: `frc_dither_top`

## Requirements
- R1: After reset `out_valid` and `out_bits` are 0, and the frame index is 0. The first frame after reset lights a level-1 pixel at coordinate (0,0).
- R2: The frame index advances by one in each cycle that has `frame_start` high. It counts 0,1,…,6 and then returns to 0. It holds in all other cycles.
- R3: Level 0 never lights a channel and level 7 always lights it, whatever the frame, position or mode.
- R4: A channel is lit when ((f + ((x + 3·y) mod 7) + c) mod 7) < L. Here f is the frame index, x and y are the pixel coordinates, c is the channel's phase offset and L is its 3-bit level.
- R5: For a fixed pixel, a level L lights its channel in exactly L of any 7 consecutive frames.
- R6: When `color_mode` is 1, red is `pix_data[8:6]` with offset 0 and drives `out_bits[2]`. Green is `pix_data[5:3]` with offset 2 and drives `out_bits[1]`. Blue is `pix_data[2:0]` with offset 4 and drives `out_bits[0]`. These are the default offsets.
- R7: When `color_mode` is 0, the gray level is `pix_data[2:0]` with offset 0 and drives `out_bits[0]`. `out_bits[2:1]` are 0, and `pix_data[8:3]` has no effect.
- R8: The output comes one cycle after the input. `out_valid` equals `pix_valid` of the previous cycle, and `out_bits` is 0 whenever `out_valid` is 0.
- R9: A pixel presented in the same cycle as `frame_start` uses the frame index from before that strobe advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Advances the frame index at this clock edge |
| color_mode | input | 1 | 1 = three-channel colour, 0 = single gray channel |
| pix_valid | input | 1 | Pixel on the inputs is valid |
| pix_x | input | X_W | Horizontal pixel coordinate |
| pix_y | input | Y_W | Vertical pixel coordinate |
| pix_data | input | 9 | Three 3-bit levels {red, green, blue}; gray in [2:0] |
| out_valid | output | 1 | Registered copy of `pix_valid` |
| out_bits | output | 3 | Lit decisions {red, green, blue}; gray on bit 0 |

## Verification
The bench builds the block with X_W = 6 and Y_W = 5. This puts the largest coordinates (63, 31) within easy reach, and short random streams cover all seven position phases many times over. With these narrow coordinates the modulo-7 fold can be checked at its extremes as well as across the interior. The frame index is walked through several full wraps, and each level is held on one pixel for a complete 7-frame cycle in both modes.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int LVL_W = 3;
  localparam int NCH   = 3;
  localparam int CYCLE = (1 << LVL_W) - 1;
  localparam int DATA_W = LVL_W * NCH;

  // Residue modulo 7: since 8 = 1 (mod 7), summing 3-bit digits keeps the residue.
  function automatic logic [2:0] mod7(input logic [31:0] v);
    logic [31:0] a;
    a = v;
    for (int i = 0; i < 11; i++) begin
      a = (a >> 3) + (a & 32'd7);
    end
    return (a >= 32'd7) ? 3'(a - 32'd7) : a[2:0];
  endfunction

  // Phase within the 7-frame cycle for one channel.
  function automatic logic [2:0] chan_phase(input logic [2:0] pos_ph,
                                            input logic [2:0] frame,
                                            input logic [2:0] off);
    return mod7(32'(pos_ph) + 32'(frame) + 32'(off));
  endfunction

  // Lit when the phase falls within the first 'level' slots of the cycle.
  function automatic logic lit_at(input logic [2:0] level, input logic [2:0] phase);
    return phase < level;
  endfunction
endpackage

// File: rtl/frc_frame_ctr.sv
module frc_frame_ctr
  import frc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  output logic [2:0] frame_idx
);
  localparam logic [2:0] LAST = 3'(CYCLE - 1);

  logic at_last;
  assign at_last = (frame_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_idx <= '0;
    end else if (frame_start) begin
      frame_idx <= at_last ? 3'd0 : frame_idx + 3'd1;
    end
  end

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx <= LAST);                                               // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_idx == LAST) |=> (frame_idx == 3'd0));      // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(frame_idx));                             // R2
endmodule

// File: rtl/frc_pos_phase.sv
module frc_pos_phase
  import frc_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 10
) (
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  output logic [2:0]     pos_ph
);
  localparam int WIDE  = (X_W > Y_W + 2) ? X_W : Y_W + 2;
  localparam int POS_W = WIDE + 1;

  logic [POS_W-1:0] xe, ye, pos_sum;

  assign xe      = POS_W'(pix_x);
  assign ye      = POS_W'(pix_y);
  assign pos_sum = xe + (ye << 1) + ye;
  assign pos_ph  = mod7(32'(pos_sum));
endmodule

// File: rtl/frc_chan_cell.sv
module frc_chan_cell
  import frc_pkg::*;
(
  input  logic [2:0] level,
  input  logic [2:0] pos_ph,
  input  logic [2:0] frame_idx,
  input  logic [2:0] ch_off,
  output logic       lit
);
  logic [2:0] phase;

  assign phase = chan_phase(pos_ph, frame_idx, ch_off);
  assign lit   = lit_at(level, phase);

  always_comb begin
    AST_LEVEL_EXTREMES: assert (!((level == 3'd0 && lit) || (level == 3'd7 && !lit))); // R3
  end
endmodule

// File: rtl/frc_dither_top.sv
module frc_dither_top
  import frc_pkg::*;
#(
  parameter int         X_W        = 11,
  parameter int         Y_W        = 10,
  parameter logic [8:0] CH_OFFSETS = {3'd0, 3'd2, 3'd4}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           color_mode,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  input  logic [8:0]     pix_data,
  output logic           out_valid,
  output logic [2:0]     out_bits
);
  logic [2:0]     frame_idx;
  logic [2:0]     pos_ph;
  logic [NCH-1:0] lit_v;
  logic [2:0]     next_bits;

  frc_frame_ctr u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .frame_idx  (frame_idx)
  );

  frc_pos_phase #(.X_W(X_W), .Y_W(Y_W)) u_pos (
    .pix_x (pix_x),
    .pix_y (pix_y),
    .pos_ph(pos_ph)
  );

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    logic [2:0] ch_off;
    if (g == 0) begin : gen_shared
      // Channel 0 doubles as the gray channel, which runs at zero offset.
      assign ch_off = color_mode ? CH_OFFSETS[2:0] : 3'd0;
    end else begin : gen_fixed
      assign ch_off = CH_OFFSETS[3*g +: 3];
    end
    frc_chan_cell u_cell (
      .level    (pix_data[LVL_W*g +: LVL_W]),
      .pos_ph   (pos_ph),
      .frame_idx(frame_idx),
      .ch_off   (ch_off),
      .lit      (lit_v[g])
    );
  end

  always_comb begin
    next_bits = '0;
    if (color_mode) next_bits = lit_v;
    else            next_bits[0] = lit_v[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      out_valid <= pix_valid;
      out_bits  <= pix_valid ? next_bits : 3'd0;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);                                                 // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && out_bits == 3'd0));                         // R8
  AST_GRAY_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !color_mode && pix_data[2:0] == 3'd0) |=> !out_bits[0]);    // R3
  AST_GRAY_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !color_mode && pix_data[2:0] == 3'd7) |=> out_bits[0]);     // R3
  AST_RED_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && color_mode && pix_data[8:6] == 3'd7) |=> out_bits[2]);      // R6
  AST_MONO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !color_mode) |=> (out_bits[2:1] == 2'b00));                 // R7
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_ph < 3'd7);                                                           // R4
endmodule

// File: tb/frc_dither_top_tb.sv
`timescale 1ns/1ps
module frc_dither_top_tb;
  localparam int XW = 6;
  localparam int YW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic          color_mode = 1'b0;
  logic          pix_valid = 1'b0;
  logic [XW-1:0] pix_x = '0;
  logic [YW-1:0] pix_y = '0;
  logic [8:0]    pix_data = '0;
  logic          out_valid;
  logic [2:0]    out_bits;

  int   n_checks = 0;
  int   n_fails  = 0;
  int   fc = 0;
  bit   prev_fs = 1'b0;
  bit   exp_valid = 1'b0;
  logic [2:0] exp_bits = 3'd0;
  string exp_tag = "R1";
  int   ones [3];

  always #4 clk = ~clk;

  frc_dither_top #(.X_W(XW), .Y_W(YW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .color_mode(color_mode),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data),
    .out_valid(out_valid), .out_bits(out_bits)
  );

  // Behavioural reference: R4 formula with R6/R7 channel mapping.
  function automatic logic [2:0] model(bit mode, logic [8:0] d, int x, int y, int f);
    int offs [3];
    int base;
    logic [2:0] r;
    offs[0] = 4; offs[1] = 2; offs[2] = 0;
    base = (x + 3 * y) % 7;
    r = 3'd0;
    for (int ch = 0; ch < 3; ch++) begin
      int lvl;
      int off;
      lvl = int'(d[3*ch +: 3]);
      off = mode ? offs[ch] : 0;
      r[ch] = (((f + base + off) % 7) < lvl);
    end
    if (!mode) r[2:1] = 2'b00;
    return r;
  endfunction

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // One cycle: compare the previous cycle's result, then drive the next input.
  task automatic step(bit fs, bit mode, bit vld, int x, int y, logic [8:0] d, string tag);
    @(negedge clk);
    check({exp_tag, " valid"}, int'(out_valid), int'(exp_valid));
    check({exp_tag, " bits"},  int'(out_bits),  int'(exp_bits));
    if (out_valid) for (int ch = 0; ch < 3; ch++) ones[ch] += int'(out_bits[ch]);
    if (prev_fs) fc = (fc == 6) ? 0 : fc + 1;    // R2 / R9: pixel saw old index
    frame_start = fs; color_mode = mode; pix_valid = vld;
    pix_x = XW'(x); pix_y = YW'(y); pix_data = d;
    prev_fs   = fs;
    exp_valid = vld;
    exp_bits  = vld ? model(mode, d, x, y, fc) : 3'd0;   // R8
    exp_tag   = tag;
  endtask

  initial begin
    #(200000 * 8);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 valid", int'(out_valid), 0);
    check("R1 bits", int'(out_bits), 0);
    rst_n = 1'b1;
    // R1: frame index 0 lights level 1 at (0,0)
    step(0, 0, 1, 0, 0, 9'd1, "R1");
    check("R1 first", int'(model(0, 9'd1, 0, 0, 0)), 1);
    step(0, 0, 0, 0, 0, 9'd0, "R8");

    // R2: advance through several wraps, probe with a level-1 pixel
    for (int k = 0; k < 16; k++) begin
      step(1, 0, 0, 0, 0, 9'd0, "R2");
      step(0, 0, 1, 0, 0, 9'd1, "R2");
    end

    // R9: pixel together with the strobe
    for (int k = 0; k < 8; k++) step(1, 1, 1, k, 2, 9'o333, "R9");

    // R3: extremes at every position, both modes
    for (int k = 0; k < 14; k++) begin
      step(k % 3 == 0, 0, 1, k * 5, k, 9'd0, "R3");
      step(0, 0, 1, k * 5, k, 9'd7, "R3");
      step(0, 1, 1, k * 3, k, 9'o707, "R3");
    end

    // R5: each level held on one pixel for a full cycle, mono and colour
    for (int mode = 0; mode < 2; mode++) begin
      for (int lvl = 0; lvl < 8; lvl++) begin
        step(0, 0, 0, 0, 0, 9'd0, "R5");
        ones[0] = 0; ones[1] = 0; ones[2] = 0;
        for (int f = 0; f < 7; f++)
          step(1, bit'(mode), 1, 5, 3, {3'(lvl), 3'(lvl), 3'(lvl)}, "R5");
        step(0, 0, 0, 0, 0, 9'd0, "R5");
        check("R5 ch0 count", ones[0], lvl);
        if (mode == 1) begin
          check("R5 ch1 count", ones[1], lvl);
          check("R5 ch2 count", ones[2], lvl);
        end
      end
    end

    // R6/R7: boundary coordinates
    for (int lvl = 0; lvl < 8; lvl++) begin
      step(lvl == 4, 1, 1, 63, 31, {3'(lvl), 3'(7 - lvl), 3'(lvl)}, "R6");
      step(0, 0, 1, 63, 31, {6'o77, 3'(lvl)}, "R7");
    end

    // R4/R6/R7/R8: random stream
    for (int k = 0; k < 600; k++) begin
      bit m;
      bit v;
      string t;
      m = bit'($urandom_range(1));
      v = ($urandom_range(3) != 0);
      t = !v ? "R8" : (m ? "R6 R4" : "R7 R4");
      step($urandom_range(7) == 0, m, v, int'($urandom_range(63)), int'($urandom_range(31)),
           9'($urandom), t);
    end
    step(0, 0, 0, 0, 0, 9'd0, "R8");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule